// File: doc/BRIEF.md
# Serial EEPROM word address counter

This block holds the internal byte pointer of a two-wire serial EEPROM. The protocol engine around it loads the pointer when a write transaction delivers its word-address byte. For the larger densities, the top of the pointer comes from the page-select bits carried in the device-address byte. The engine then pulses a step strobe after every data byte that moves through the array.

The mode flag chooses how a step behaves:

- **Write transfers:** only the in-page offset counts, so a burst longer than one page folds back onto the start of the same page.
- **Read transfers:** the whole pointer counts and rolls from the top of the array back to zero.

The pointer holds its value between transactions. A later current-address read therefore resumes one byte past the last byte touched.

Array size (256 to 2048 bytes) and page size (8 or 16 bytes) are parameters. The pointer is 8 to 11 bits wide. Bits of the page-select field above the pointer width are ignored.

Top module: `eeprom_word_addr_ctr`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, `addr_q` is zero.
- R2: A cycle with `load_en` high sets `addr_q` to `{dev_hi[HI-1:0], word_byte}`, where HI = log2(MEM_BYTES) - 8 (0 to 3); with HI = 0 it sets `addr_q` to `word_byte`.
- R3: A cycle with `step_en` high, `rd_mode` low (write) and `load_en` low adds one to the low log2(PAGE_BYTES) bits of `addr_q` and leaves the higher bits unchanged.
- R4: A write step from the last byte of a page sets the low log2(PAGE_BYTES) bits to zero, keeping the page.
- R5: A cycle with `step_en` high, `rd_mode` high (read) and `load_en` low adds one to the whole of `addr_q`, carrying across page boundaries.
- R6: A read step from address MEM_BYTES-1 gives address 0.
- R7: With `load_en` and `step_en` both low, `addr_q` holds, so a later read resumes at the last accessed address plus one.
- R8: When `load_en` and `step_en` are high in the same cycle, the load wins and no step is applied.
- R9: Bits of `dev_hi` at or above position HI have no effect on `addr_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load the pointer from `dev_hi` and `word_byte` |
| dev_hi | input | 3 | Page-select bits from the device-address byte |
| word_byte | input | 8 | Word-address byte |
| step_en | input | 1 | Advance after a transferred byte |
| rd_mode | input | 1 | 1 = read transfer (full rollover), 0 = write transfer (in-page fold) |
| addr_q | output | log2(MEM_BYTES) | Current word address |

## Verification
The in-RTL properties check the following on every cycle:

- a write step never disturbs the page bits;
- a write step at the page end lands on offset zero;
- a read step is exactly one above the previous value;
- an idle cycle leaves the pointer stable;
- a load captures the word byte even when a step arrives with it.

Only the bench's scenarios can show certain cases, because they depend on chosen values and on the parameter variant in use:

- a full-array rollover at 2048 bytes;
- the upper bits coming from the page-select field;
- the unused page-select bits being ignored on the 256-byte variant;
- a read resuming after a write burst.

The bench drives one small and one large instance with the same stimulus, and compares both against a behavioural model on every clock.

// File: rtl/eeprom_word_addr_ctr.sv
module eeprom_word_addr_ctr #(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_en,
  input  logic [2:0]                   dev_hi,
  input  logic [7:0]                   word_byte,
  input  logic                         step_en,
  input  logic                         rd_mode,
  output logic [$clog2(MEM_BYTES)-1:0] addr_q
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int HI = AW - 8;

  logic [AW-1:0] load_val, wr_next, rd_next;
  wire unused_hi = ^dev_hi;

  generate
    if (HI > 0) begin : g_paged
      assign load_val = {dev_hi[HI-1:0], word_byte};
    end else begin : g_flat
      assign load_val = word_byte;
    end
  endgenerate

  assign wr_next = {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
  assign rd_next = addr_q + AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)       addr_q <= '0;
    else if (load_en) addr_q <= load_val;
    else if (step_en) addr_q <= rd_mode ? rd_next : wr_next;
  end

  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !rd_mode && !load_en) |=> addr_q[AW-1:PW] == $past(addr_q[AW-1:PW]));

  // R4
  page_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !rd_mode && !load_en && addr_q[PW-1:0] == {PW{1'b1}}) |=> addr_q[PW-1:0] == '0);

  // R5
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && rd_mode && !load_en) |=> addr_q == AW'($past(addr_q) + AW'(1)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> $stable(addr_q));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> addr_q[7:0] == $past(word_byte));
endmodule

// File: tb/eeprom_word_addr_ctr_tb_top.sv
module eeprom_word_addr_ctr_tb_top;
  logic clk = 0, rst_n = 0, load_en = 0, step_en = 0, rd_mode = 0;
  logic [2:0] dev_hi = 0;
  logic [7:0] word_byte = 0;
  logic [7:0]  a_small;
  logic [10:0] a_wide;
  int checks = 0, fails = 0;
  int m_small = 0, m_wide = 0;
  string tag = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  eeprom_word_addr_ctr #(.MEM_BYTES(256), .PAGE_BYTES(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .dev_hi(dev_hi), .word_byte(word_byte),
    .step_en(step_en), .rd_mode(rd_mode), .addr_q(a_small));
  eeprom_word_addr_ctr #(.MEM_BYTES(2048), .PAGE_BYTES(16)) dut_w (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .dev_hi(dev_hi), .word_byte(word_byte),
    .step_en(step_en), .rd_mode(rd_mode), .addr_q(a_wide));

  function automatic int model_next(int cur, int mem, int page);
    int hi_span = mem / 256;
    if (!rst_n) return 0;
    if (load_en) return (int'(dev_hi) % hi_span) * 256 + int'(word_byte);
    if (!step_en) return cur;
    if (rd_mode) return (cur + 1) % mem;
    return (cur / page) * page + ((cur % page) + 1) % page;
  endfunction

  always @(posedge clk) begin
    m_small <= model_next(m_small, 256, 8);
    m_wide  <= model_next(m_wide, 2048, 16);
  end

  always @(negedge clk) if (!done) begin
    checks += 2;
    if (int'(a_small) != m_small) begin
      fails++;
      $display("FAIL %s small: actual %0h expected %0h", tag, a_small, m_small);
    end
    if (int'(a_wide) != m_wide) begin
      fails++;
      $display("FAIL %s wide: actual %0h expected %0h", tag, a_wide, m_wide);
    end
  end

  task automatic cyc(bit ld, bit st, bit rd, logic [2:0] h, logic [7:0] w);
    load_en = ld; step_en = st; rd_mode = rd; dev_hi = h; word_byte = w;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    tag = "R1"; rst_n = 1; @(negedge clk);
    tag = "R2";  cyc(1, 0, 0, 3'b101, 8'hF5); cyc(0, 0, 0, 0, 0);
    tag = "R9";  cyc(1, 0, 0, 3'b111, 8'h3C); cyc(0, 0, 0, 0, 0);
    tag = "R3";  cyc(1, 0, 0, 3'b010, 8'h40);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0);
    tag = "R4";  cyc(1, 0, 0, 3'b101, 8'hFD);
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 0, 0);
    tag = "R7";  for (int i = 0; i < 4; i++) cyc(0, 0, 1, 3'b110, 8'hAA);
    tag = "R5";  for (int i = 0; i < 12; i++) cyc(0, 1, 1, 0, 0);
    tag = "R6";  cyc(1, 0, 0, 3'b111, 8'hFE);
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 0);
    tag = "R8";  cyc(1, 1, 1, 3'b011, 8'h77); cyc(1, 1, 0, 3'b001, 8'h0F); cyc(0, 0, 0, 0, 0);
    tag = "R3";  cyc(1, 0, 0, 3'b000, 8'h07); cyc(0, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0);
    tag = "R7";  cyc(0, 0, 0, 0, 0); cyc(0, 1, 1, 0, 0); cyc(0, 0, 0, 0, 0);
    tag = "R1";  rst_n = 0; cyc(0, 1, 1, 0, 0); rst_n = 1; cyc(0, 0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule